// File: doc/BRIEF.md
# Real-Mode Interrupt Dispatch Sequencer

This block performs the entry and return sequences of interrupts and exceptions for a processor core running in segmented real-address mode. A request carries an 8-bit vector number. The block checks that vector's slot in a relocatable vector table. It saves the flags word and the return CS:IP on the stack and fetches the handler's far pointer. It then presents the new CS, IP, flags and SP to the core. A separate return command unwinds the same stack frame.

The table is described by a base/limit register that software can reload. Each slot is four bytes long. A slot that extends past the limit is not used, and vector 8 is dispatched in its place. If slot 8 is also past the limit, the block stops in a shutdown state. All memory traffic goes through one 16-bit port with a request/ready handshake, and that port may stall for any number of cycles.

Top module: `rm_irq_seq`

## Requirements
- R1: After reset, `busy`, `done`, `shutdown` and `mem_req` are 0. The table base is 0 and the table limit is 0x3FF, so vector 255 (slot bytes 0x3FC..0x3FF) is dispatched unchanged.
- R2: A vector V is dispatched from the slot at base + 4*V. The 16-bit word at that address becomes `ip_out`, and the word at base + 4*V + 2 becomes `cs_out`.
- R3: On entry, three words are written to the stack in this order: FLAGS at SS*16 + SP - 2, then CS at SS*16 + SP - 4, then IP at SS*16 + SP - 6. `sp_out` is SP - 6, with SP arithmetic taken modulo 2^16.
- R4: On entry, `flags_out` equals the input flags with bit 9 (interrupt enable) and bit 8 (single-step trap) cleared. All other bits are unchanged.
- R5: A one-cycle `tbl_load` pulse replaces the base and limit. Requests accepted afterwards use the new values.
- R6: Vector V is out of range when 4*V + 3 > limit. In that case vector 8 is dispatched instead and `vec_used` reads 8. A slot whose last byte equals the limit is in range.
- R7: If the substitute vector 8 (4*8 + 3 = 35 > limit) is itself out of range, `shutdown` rises and stays high until reset. `busy` is 0, and later requests cause no memory traffic and no `done`.
- R8: A return pops IP from SS*16 + SP, then CS from +2, then FLAGS from +4. These values become `ip_out`, `cs_out` and `flags_out`, and `sp_out` is SP + 6.
- R9: While `mem_req` is high and `mem_rdy` is low, the port holds `mem_addr`, `mem_we` and `mem_wdata` steady. A transfer completes on an edge where both are high.
- R10: `busy` is high from the cycle after a command is accepted until the results are ready. `done` is a one-cycle pulse. Commands presented while busy are ignored.
- R11: If `req_valid` and `ret_valid` are both high in the same idle cycle, the entry sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an entry sequence for `req_vec` |
| req_vec | input | 8 | Requested vector number |
| ret_valid | input | 1 | Start a return sequence |
| tbl_load | input | 1 | Load a new table base and limit |
| tbl_base_in | input | 24 | New table base (byte address) |
| tbl_limit_in | input | 16 | New table limit (last valid byte offset) |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| flags_in | input | 16 | Current flags word |
| ss_in | input | 16 | Current stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the word transfer |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_rdy` is high |
| mem_rdy | input | 1 | Memory accepts or completes the transfer this cycle |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse: new CS/IP/flags/SP are valid |
| shutdown | output | 1 | Sticky halt after a double out-of-range fault |
| cs_out | output | 16 | New code segment |
| ip_out | output | 16 | New instruction pointer |
| flags_out | output | 16 | New flags word |
| sp_out | output | 16 | New stack pointer |
| vec_used | output | 8 | Vector actually dispatched by the last entry |

## Verification
`busy` is due at the first falling edge after the accepting clock edge, and the bench samples it there. `done` follows the last memory transfer by one register. Because the port stalls at random, the bench waits for `done` rather than counting to it, then checks that it drops one cycle later. The new CS, IP, flags, SP and `vec_used` are read in the `done` cycle and compared with values the bench computes from its own copy of the table and stack. During a forced stall, the first push request is checked at every falling edge from the second cycle after acceptance. `shutdown` is checked a few cycles after a doubly out-of-range request, and the port is then watched for ten cycles for silence.

// File: rtl/rmid_pkg.sv
package rmid_pkg;
  parameter int RMID_AW = 24;
  localparam int IF_BIT = 9;
  localparam int TF_BIT = 8;
  localparam logic [7:0] VEC_DF = 8'd8;
  localparam logic [15:0] RST_LIMIT = 16'h03FF;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_PUSH_F, S_PUSH_CS, S_PUSH_IP,
    S_RD_OFF, S_RD_SEG, S_POP_IP, S_POP_CS, S_POP_F, S_HALT
  } seq_state_t;

  // Byte offset of a vector slot inside the table.
  function automatic logic [15:0] tbl_off(input logic [7:0] v);
    return {6'b0, v, 2'b00};
  endfunction

  // Slot is out of range when its last byte lies past the limit.
  function automatic logic slot_oor(input logic [7:0] v, input logic [15:0] lim);
    logic [16:0] last;
    last = {1'b0, tbl_off(v)} + 17'd3;
    return last > {1'b0, lim};
  endfunction

  // Linear stack address from segment and pointer.
  function automatic logic [RMID_AW-1:0] stk_addr(input logic [15:0] ss, input logic [15:0] sp);
    logic [19:0] lin;
    lin = {ss, 4'h0} + {4'h0, sp};
    return RMID_AW'(lin);
  endfunction

  // Handler flags: interrupt enable and trap cleared.
  function automatic logic [15:0] entry_flags(input logic [15:0] f);
    logic [15:0] r;
    r = f;
    r[IF_BIT] = 1'b0;
    r[TF_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/rmid_tbl_reg.sv
module rmid_tbl_reg #(
  parameter int AW = rmid_pkg::RMID_AW,
  parameter logic [AW-1:0] RST_BASE = '0,
  parameter logic [15:0] RST_LIM = rmid_pkg::RST_LIMIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic [15:0]   limit_in,
  output logic [AW-1:0] base,
  output logic [15:0]   limit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= RST_BASE;
      limit <= RST_LIM;
    end else if (load) begin
      base  <= base_in;
      limit <= limit_in;
    end
  end
endmodule

// File: rtl/rmid_range_chk.sv
module rmid_range_chk #(
  parameter int AW = rmid_pkg::RMID_AW
) (
  input  logic [7:0]    vec,
  input  logic [AW-1:0] base,
  input  logic [15:0]   limit,
  input  logic          word_sel,
  output logic [AW-1:0] entry_addr,
  output logic          out_of_range
);
  import rmid_pkg::*;
  localparam logic [AW-1:0] SEG_STEP = AW'(2);

  always_comb begin
    entry_addr   = base + AW'(tbl_off(vec)) + (word_sel ? SEG_STEP : '0);
    out_of_range = slot_oor(vec, limit);
  end
endmodule

// File: rtl/rmid_seq_ctl.sv
module rmid_seq_ctl #(
  parameter int AW = rmid_pkg::RMID_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [7:0]    req_vec,
  input  logic          ret_valid,
  input  logic [15:0]   cs_in,
  input  logic [15:0]   ip_in,
  input  logic [15:0]   flags_in,
  input  logic [15:0]   ss_in,
  input  logic [15:0]   sp_in,
  input  logic [AW-1:0] entry_addr,
  input  logic          out_of_range,
  output logic [7:0]    chk_vec,
  output logic          word_sel,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_rdy,
  output logic          busy,
  output logic          done,
  output logic          shutdown,
  output logic [15:0]   cs_out,
  output logic [15:0]   ip_out,
  output logic [15:0]   flags_out,
  output logic [15:0]   sp_out,
  output logic [7:0]    vec_used,
  output logic          is_entry,
  output logic          ev_accept_entry,
  output logic          ev_accept_ret,
  output logic          ev_remap,
  output logic          ev_halt,
  output logic          ev_xfer
);
  import rmid_pkg::*;

  seq_state_t st;
  logic [7:0]  vec_q;
  logic [15:0] cs_q, ip_q, flags_q, ss_q, sp_q, word_q;
  logic [15:0] sp_dec, sp_inc;

  assign sp_dec   = sp_q - 16'd2;
  assign sp_inc   = sp_q + 16'd2;
  assign chk_vec  = vec_q;
  assign busy     = (st != S_IDLE) && (st != S_HALT);
  assign shutdown = (st == S_HALT);

  assign ev_accept_entry = (st == S_IDLE) && req_valid;
  assign ev_accept_ret   = (st == S_IDLE) && !req_valid && ret_valid;
  assign ev_remap        = (st == S_CHECK) && out_of_range && (vec_q != VEC_DF);
  assign ev_halt         = (st == S_CHECK) && out_of_range && (vec_q == VEC_DF);
  assign ev_xfer         = mem_req && mem_rdy;

  // Memory port: driven only from registered state, so it holds during stalls.
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    word_sel  = 1'b0;
    case (st)
      S_PUSH_F:  begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_addr(ss_q, sp_dec); mem_wdata = flags_q; end
      S_PUSH_CS: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_addr(ss_q, sp_dec); mem_wdata = cs_q; end
      S_PUSH_IP: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = stk_addr(ss_q, sp_dec); mem_wdata = ip_q; end
      S_RD_OFF:  begin mem_req = 1'b1; mem_addr = entry_addr; end
      S_RD_SEG:  begin mem_req = 1'b1; word_sel = 1'b1; mem_addr = entry_addr; end
      S_POP_IP, S_POP_CS, S_POP_F: begin mem_req = 1'b1; mem_addr = stk_addr(ss_q, sp_q); end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vec_q     <= '0;
      cs_q      <= '0;
      ip_q      <= '0;
      flags_q   <= '0;
      ss_q      <= '0;
      sp_q      <= '0;
      word_q    <= '0;
      is_entry  <= 1'b0;
      done      <= 1'b0;
      cs_out    <= '0;
      ip_out    <= '0;
      flags_out <= '0;
      sp_out    <= '0;
      vec_used  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ev_accept_entry) begin
            vec_q    <= req_vec;
            cs_q     <= cs_in;
            ip_q     <= ip_in;
            flags_q  <= flags_in;
            ss_q     <= ss_in;
            sp_q     <= sp_in;
            is_entry <= 1'b1;
            st       <= S_CHECK;
          end else if (ev_accept_ret) begin
            ss_q     <= ss_in;
            sp_q     <= sp_in;
            is_entry <= 1'b0;
            st       <= S_POP_IP;
          end
        end
        S_CHECK: begin
          if (ev_halt)        st    <= S_HALT;
          else if (ev_remap)  vec_q <= VEC_DF;
          else                st    <= S_PUSH_F;
        end
        S_PUSH_F:  if (ev_xfer) begin sp_q <= sp_dec; st <= S_PUSH_CS; end
        S_PUSH_CS: if (ev_xfer) begin sp_q <= sp_dec; st <= S_PUSH_IP; end
        S_PUSH_IP: if (ev_xfer) begin sp_q <= sp_dec; st <= S_RD_OFF;  end
        S_RD_OFF:  if (ev_xfer) begin word_q <= mem_rdata; st <= S_RD_SEG; end
        S_RD_SEG: begin
          if (ev_xfer) begin
            cs_out    <= mem_rdata;
            ip_out    <= word_q;
            flags_out <= entry_flags(flags_q);
            sp_out    <= sp_q;
            vec_used  <= vec_q;
            done      <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_POP_IP: if (ev_xfer) begin word_q <= mem_rdata; sp_q <= sp_inc; st <= S_POP_CS; end
        S_POP_CS: if (ev_xfer) begin cs_q <= mem_rdata;   sp_q <= sp_inc; st <= S_POP_F;  end
        S_POP_F: begin
          if (ev_xfer) begin
            flags_out <= mem_rdata;
            cs_out    <= cs_q;
            ip_out    <= word_q;
            sp_out    <= sp_inc;
            done      <= 1'b1;
            st        <= S_IDLE;
          end
        end
        S_HALT:  st <= S_HALT;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rm_irq_seq.sv
module rm_irq_seq #(
  parameter int AW = rmid_pkg::RMID_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [7:0]    req_vec,
  input  logic          ret_valid,
  input  logic          tbl_load,
  input  logic [AW-1:0] tbl_base_in,
  input  logic [15:0]   tbl_limit_in,
  input  logic [15:0]   cs_in,
  input  logic [15:0]   ip_in,
  input  logic [15:0]   flags_in,
  input  logic [15:0]   ss_in,
  input  logic [15:0]   sp_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_rdy,
  output logic          busy,
  output logic          done,
  output logic          shutdown,
  output logic [15:0]   cs_out,
  output logic [15:0]   ip_out,
  output logic [15:0]   flags_out,
  output logic [15:0]   sp_out,
  output logic [7:0]    vec_used
);
  logic [AW-1:0] tbl_base;
  logic [15:0]   tbl_limit;
  logic [AW-1:0] entry_addr;
  logic          out_of_range;
  logic [7:0]    chk_vec;
  logic          word_sel;
  logic          is_entry;
  logic          ev_accept_entry, ev_accept_ret, ev_remap, ev_halt, ev_xfer;
  logic          done_entry;

  assign done_entry = done && is_entry;

  rmid_tbl_reg #(.AW(AW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .load(tbl_load),
    .base_in(tbl_base_in), .limit_in(tbl_limit_in),
    .base(tbl_base), .limit(tbl_limit)
  );

  rmid_range_chk #(.AW(AW)) u_rng (
    .vec(chk_vec), .base(tbl_base), .limit(tbl_limit), .word_sel(word_sel),
    .entry_addr(entry_addr), .out_of_range(out_of_range)
  );

  rmid_seq_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vec(req_vec), .ret_valid(ret_valid),
    .cs_in(cs_in), .ip_in(ip_in), .flags_in(flags_in), .ss_in(ss_in), .sp_in(sp_in),
    .entry_addr(entry_addr), .out_of_range(out_of_range),
    .chk_vec(chk_vec), .word_sel(word_sel),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .busy(busy), .done(done), .shutdown(shutdown),
    .cs_out(cs_out), .ip_out(ip_out), .flags_out(flags_out), .sp_out(sp_out),
    .vec_used(vec_used), .is_entry(is_entry),
    .ev_accept_entry(ev_accept_entry), .ev_accept_ret(ev_accept_ret),
    .ev_remap(ev_remap), .ev_halt(ev_halt), .ev_xfer(ev_xfer)
  );
endmodule

// File: rtl/rmid_chk.sv
module rmid_chk #(
  parameter int AW = rmid_pkg::RMID_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_rdy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          busy,
  input logic          done,
  input logic          shutdown,
  input logic [15:0]   flags_out,
  input logic          done_entry,
  input logic [7:0]    chk_vec,
  input logic          ev_accept_entry,
  input logic          ev_accept_ret,
  input logic          ev_remap,
  input logic          ev_halt,
  input logic          ev_xfer
);
  assert_port_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_xfer_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer |-> busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_entry |=> busy);

  assert_busy_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept_ret |=> busy);

  assert_flags_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_entry |-> ((flags_out & 16'h0300) == 16'h0000));

  assert_remap_vec8_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_remap |=> (chk_vec == 8'd8));

  assert_halt_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> shutdown);

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> shutdown);

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!mem_req && !busy && !done));
endmodule

bind rm_irq_seq rmid_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
  .shutdown(shutdown), .flags_out(flags_out), .done_entry(done_entry),
  .chk_vec(chk_vec), .ev_accept_entry(ev_accept_entry), .ev_accept_ret(ev_accept_ret),
  .ev_remap(ev_remap), .ev_halt(ev_halt), .ev_xfer(ev_xfer)
);

// File: tb/sim_rm_irq_seq.sv
module sim_rm_irq_seq;
  localparam int AW = rmid_pkg::RMID_AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_valid, ret_valid, tbl_load;
  logic [7:0] req_vec;
  logic [AW-1:0] tbl_base_in;
  logic [15:0] tbl_limit_in, cs_in, ip_in, flags_in, ss_in, sp_in;
  logic mem_req, mem_we, mem_rdy;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic busy, done, shutdown;
  logic [15:0] cs_out, ip_out, flags_out, sp_out;
  logic [7:0] vec_used;

  rm_irq_seq u0 (.*);

  logic [15:0] mem [int unsigned];
  int n_chk = 0, n_bad = 0, cyc = 0, stall_pct = 30;
  bit rdy_low = 1'b0, wd_hit = 1'b0;
  logic [AW-1:0] cur_base;
  int cur_lim;

  function automatic logic [15:0] rd(input logic [AW-1:0] a);
    if (mem.exists(32'(a))) return mem[32'(a)];
    return 16'h0000;
  endfunction

  function automatic logic [AW-1:0] lin(input logic [15:0] ss, input logic [15:0] sp);
    int unsigned v;
    v = (32'(ss) * 16) + 32'(sp);
    return AW'(v);
  endfunction

  function automatic int exp_vec(input int v, input int lim);
    if (v * 4 + 3 <= lim) return v;
    if (35 <= lim) return 8;
    return -1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (mem_req && mem_rdy && mem_we) mem[32'(mem_addr)] = mem_wdata;
  end

  always @(negedge clk) begin
    mem_rdy   <= rdy_low ? 1'b0 : (($urandom % 100) >= stall_pct);
    mem_rdata <= rd(mem_addr);
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog act=%0d exp<150000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
    chk({tag, " done seen"}, 32'(seen), 32'd1);
  endtask

  task automatic load_tbl(input logic [AW-1:0] b, input int lim);
    @(negedge clk);
    tbl_load = 1'b1; tbl_base_in = b; tbl_limit_in = 16'(lim);
    @(negedge clk);
    tbl_load = 1'b0;
    cur_base = b; cur_lim = lim;
  endtask

  // mode bit0: raise ret_valid too (R11); bit1: poke while busy (R10); bit2: forced stall (R9)
  task automatic run_entry(input int v, input logic [15:0] cs, input logic [15:0] ip,
                           input logic [15:0] fl, input logic [15:0] ss, input logic [15:0] sp,
                           input int mode);
    int ev;
    logic [AW-1:0] ea;
    logic [15:0] h_off, h_seg;
    ev = exp_vec(v, cur_lim);
    ea = cur_base + AW'(ev * 4);
    h_off = 16'($urandom); h_seg = 16'($urandom);
    mem[32'(ea)] = h_off;
    mem[32'(ea + AW'(2))] = h_seg;
    if (mode[2]) rdy_low = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_vec = 8'(v); ret_valid = mode[0];
    cs_in = cs; ip_in = ip; flags_in = fl; ss_in = ss; sp_in = sp;
    @(negedge clk);
    req_valid = 1'b0; ret_valid = 1'b0;
    chk("R10 busy after accept", 32'(busy), 32'd1);
    if (mode[1]) begin
      req_valid = 1'b1; req_vec = 8'(v ^ 8'h5A); ret_valid = 1'b1;
      cs_in = ~cs; ip_in = ~ip; flags_in = ~fl; sp_in = sp + 16'h0100;
      @(negedge clk);
      req_valid = 1'b0; ret_valid = 1'b0;
    end
    if (mode[2]) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk("R9 stall req held", 32'(mem_req), 32'd1);
        chk("R9 stall addr held", 32'(mem_addr), 32'(lin(ss, sp - 16'd2)));
        chk("R9 stall wdata held", {15'd0, mem_we, mem_wdata}, {15'd0, 1'b1, fl});
      end
      rdy_low = 1'b0;
    end
    wait_done("R10 entry");
    chk("R6 vec_used", 32'(vec_used), 32'(ev));
    chk("R2 ip_out from slot offset", 32'(ip_out), 32'(h_off));
    chk("R2 cs_out from slot segment", 32'(cs_out), 32'(h_seg));
    chk("R4 flags_out IF/TF cleared", 32'(flags_out), 32'(fl & 16'hFCFF));
    chk("R3 sp_out", 32'(sp_out), 32'(16'(sp - 16'd6)));
    chk("R3 pushed flags", 32'(rd(lin(ss, sp - 16'd2))), 32'(fl));
    chk("R3 pushed cs", 32'(rd(lin(ss, sp - 16'd4))), 32'(cs));
    chk("R3 pushed ip", 32'(rd(lin(ss, sp - 16'd6))), 32'(ip));
    @(negedge clk);
    chk("R10 done single pulse", 32'(done), 32'd0);
  endtask

  task automatic run_ret(input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] fl,
                         input logic [15:0] ss, input logic [15:0] sp);
    @(negedge clk);
    ret_valid = 1'b1; ss_in = ss; sp_in = sp;
    cs_in = 16'h0BAD; ip_in = 16'h0BAD; flags_in = 16'h0BAD;
    @(negedge clk);
    ret_valid = 1'b0;
    chk("R10 busy after return accept", 32'(busy), 32'd1);
    wait_done("R8 return");
    chk("R8 ip restored", 32'(ip_out), 32'(ip));
    chk("R8 cs restored", 32'(cs_out), 32'(cs));
    chk("R8 flags restored", 32'(flags_out), 32'(fl));
    chk("R8 sp_out", 32'(sp_out), 32'(16'(sp + 16'd6)));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; ret_valid = 1'b0; tbl_load = 1'b0; req_vec = '0;
    tbl_base_in = '0; tbl_limit_in = '0; cs_in = '0; ip_in = '0; flags_in = '0;
    ss_in = '0; sp_in = '0;
    cur_base = '0; cur_lim = 16'h03FF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 shutdown", 32'(shutdown), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    // R1/R6: last slot under reset limit is usable
    run_entry(255, 16'h1234, 16'h5678, 16'hF3D7, 16'h2000, 16'h0100, 0);
    // R5/R6 boundary: limit 43 keeps vector 10; limit 42 remaps it
    load_tbl(24'h300000, 43);
    run_entry(10, 16'hAAAA, 16'h5555, 16'h0300, 16'h3000, 16'h8000, 0);
    load_tbl(24'h300000, 42);
    run_entry(10, 16'hAAAB, 16'h5554, 16'h0200, 16'h3000, 16'h8000, 0);
    // R8: stack pointer wrap through zero
    load_tbl(24'h310000, 16'h03FF);
    run_entry(33, 16'h0101, 16'h0202, 16'h0100, 16'h4000, 16'h0002, 0);
    run_ret(16'h0101, 16'h0202, 16'h0100, 16'h4000, sp_out);
    // R11: both commands at once
    run_entry(20, 16'h7777, 16'h8888, 16'h0346, 16'h5000, 16'h1000, 1);
    // R10: commands while busy are ignored
    run_entry(21, 16'h1111, 16'h2222, 16'h0F00, 16'h5000, 16'h2000, 2);
    // R9: forced stall on first push
    run_entry(40, 16'h3333, 16'h4444, 16'h0302, 16'h6000, 16'h3000, 4);
    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [15:0] rcs, rip, rfl, rss, rsp;
      int lim, v;
      lim = ($urandom % 4 == 0) ? 16'hFFFF : 35 + ($urandom % 1000);
      load_tbl(24'h200000 + AW'($urandom & 32'hFFFE), lim);
      v = $urandom % 256;
      rcs = 16'($urandom); rip = 16'($urandom); rfl = 16'($urandom);
      rss = 16'h1000 + 16'($urandom % 32'hE000);
      rsp = 16'($urandom) & 16'hFFFE;
      run_entry(v, rcs, rip, rfl, rss, rsp, 0);
      run_ret(rcs, rip, rfl, rss, 16'(rsp - 16'd6));
    end
    // R7: both requested slot and slot 8 past the limit
    load_tbl(24'h380000, 20);
    @(negedge clk);
    req_valid = 1'b1; req_vec = 8'd6; ss_in = 16'h7000; sp_in = 16'h4000;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 shutdown raised", 32'(shutdown), 32'd1);
    chk("R7 busy low in shutdown", 32'(busy), 32'd0);
    req_valid = 1'b1; req_vec = 8'd0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 10; k++) begin
      chk("R7 no traffic after shutdown", {30'd0, mem_req, done}, 32'd0);
      @(negedge clk);
    end
    chk("R7 shutdown sticky", 32'(shutdown), 32'd1);
    summary();
  end
endmodule